// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a fully associative translation buffer. It holds a parameterised number of entries (64 by default) and maps 64-bit virtual addresses to 41-bit physical addresses. Each entry stores a virtual page tag and a 13-bit context. It also stores the translation itself: valid, global, page-size code, physical page number, privileged-only, writable, no-fault-only, side-effect, invert-endian and a used flag. An outside agent writes entries through a one-cycle load port. The agent picks which slot to write and walks any page tables itself.

Lookups come in on a valid/ready request channel. The block compares all entries in the cycle of acceptance and registers the result into a response channel one cycle later. A result is a hit, a data fault, a protection trap or a miss. A response waits in its register until `rsp_ready` is high. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so the channel stalls without losing anything. A request is accepted on a clock edge where `req_valid && req_ready`.

The block also keeps three registers: fault status, fault address and tag-access. Exceptions update them as each class requires.

Top module: `tlb_xlate`

## Requirements
- R1: An entry matches when it is valid, and either its global flag is set or its context equals the lookup context, and its tag equals the virtual address above bit 12 under the entry's compare mask. A load with valid = 0 makes the slot never match.
- R2: Page-size code s (0..3) selects a page of 8 KiB, 64 KiB, 512 KiB or 4 MiB. The compare mask ignores the lowest 3·s bits of the virtual page number (address bits 13 and up).
- R3: On a hit, `rsp_ppn` (physical address bits 40:13) takes the entry's page number in the bits the mask keeps and the virtual address in the bits it ignores.
- R4: The lookup context depends on the access. `req_kind` is 0 load, 1 store, 2 non-faulting load, 3 instruction fetch. A data access with `req_space` 0 uses `ctx_primary`, 1 uses `ctx_secondary` and 2 uses context 0. A fetch uses `ctx_primary` when `trap_nz` is 0 and context 0 otherwise; it ignores `req_space`.
- R5: When several entries match, the lowest-numbered one supplies the result.
- R6: On a data hit, each of the following sets its own fault-type bit, and any of them gives code 1 (fault). The conditions are: a user access (`req_user`) to a privileged page, bit 7; a non-faulting load to a side-effect page, bit 8; any other data access to a no-fault-only page, bit 9. A fetch faults only on the privileged condition.
- R7: With no fault, a store to a non-writable page gives code 2 (protection trap) and loads status with no fault-type bits set.
- R8: A hit gives code 0 and sets the entry's bit in `entry_used`. It reports `rsp_ie` from the entry. `rsp_wr_ok` equals the writable flag for data accesses and is 0 for fetches.
- R9: A load writes the whole entry into slot `ld_idx` and clears that slot's used bit. The load wins over a hit on the same slot in the same cycle.
- R10: Codes 1 and 2 load the fault status, the fault address register with the full request address, and `tag_access` with the address whose bits 12:0 are replaced by the lookup context. The status bits are: [0] valid, [1] overwrite, [3:2] context type (0 primary, 1 secondary, 2 nucleus, 3 untranslated), [4] store, [5] non-faulting load, [6] `priv_mode`, [9:7] fault types. A fetch reports type 2 when `trap_nz` is set and 0 otherwise.
- R11: The overwrite bit is set when the status was still valid as the new exception arrived. A pulse on `fsr_clr` clears the status word. If a clear and an exception come in the same cycle, the clear is applied first.
- R12: A miss gives code 3 and updates only `tag_access`. Status and fault address keep their values.
- R13: A response appears exactly one cycle after acceptance. While `rsp_ready` is low it holds its values and `req_ready` is low.
- R14: A data access with `req_space` 3 (untranslated) does not search the table. It returns code 0 with `rsp_ppn` = address bits 40:13, `rsp_wr_ok` 1 and `rsp_ie` 0, and it marks no entry used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one entry this cycle |
| ld_idx | input | 6 | Slot to write |
| ld_va | input | 64 | Virtual address of the page (bits 63:13 used) |
| ld_ctx | input | 13 | Context of the entry |
| ld_valid | input | 1 | Entry valid |
| ld_global | input | 1 | Entry matches any context |
| ld_size | input | 2 | Page-size code |
| ld_ppn | input | 28 | Physical page number, address bits 40:13 |
| ld_priv | input | 1 | Page needs privileged access |
| ld_wr | input | 1 | Page is writable |
| ld_nfo | input | 1 | Page only allows non-faulting loads |
| ld_se | input | 1 | Page has side effects |
| ld_ie | input | 1 | Invert-endian attribute |
| ctx_primary | input | 13 | Primary context |
| ctx_secondary | input | 13 | Secondary context |
| trap_nz | input | 1 | Trap level is above zero |
| priv_mode | input | 1 | Processor is in privileged mode |
| fsr_clr | input | 1 | Clear the fault status word |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 64 | Virtual address to translate |
| req_kind | input | 2 | Access kind (R4 encoding) |
| req_space | input | 2 | Data address space (R4, R14 encoding) |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_code | output | 2 | 0 hit, 1 fault, 2 protection, 3 miss |
| rsp_ppn | output | 28 | Translated page number on a hit, else 0 |
| rsp_wr_ok | output | 1 | Write permission on a hit |
| rsp_ie | output | 1 | Invert-endian attribute on a hit |
| fsr | output | 10 | Fault status word |
| far | output | 64 | Fault address |
| tag_access | output | 64 | Last exception page and context |
| entry_used | output | 64 | Used flag of each entry |

## Verification
The embedded properties check some rules on every clock. An exception sets the status valid bit. A second unread exception sets overwrite. A miss leaves the fault address and status alone. A load clears the slot's used flag. A stalled response holds still. Other behaviour needs the bench's scenarios and its reference model. That covers priority between duplicate matches, mask arithmetic for each page size, context choice by kind and trap level, combined fault-type bits, and the protection-versus-fault ordering. It also covers the overwrite sequence after a clear and the timing of back-pressure.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 64;
  parameter int PA_W   = 41;
  parameter int CTX_W  = 13;
  parameter int PG_LSB = 13;
  localparam int VPN_W = VA_W - PG_LSB;
  localparam int PPN_W = PA_W - PG_LSB;
  localparam int FSR_W = 10;

  typedef enum logic [1:0] {K_LOAD, K_STORE, K_NFLOAD, K_FETCH} kind_e;
  typedef enum logic [1:0] {S_PRIM, S_SEC, S_NUC, S_BYPASS} space_e;
  typedef enum logic [1:0] {C_HIT, C_FAULT, C_PROT, C_MISS} code_e;

  typedef struct packed {
    logic             valid;
    logic             glob;
    logic [1:0]       size;
    logic [VPN_W-1:0] tag;
    logic [CTX_W-1:0] ctx;
    logic [PPN_W-1:0] ppn;
    logic             priv;
    logic             wr;
    logic             nfo;
    logic             se;
    logic             ie;
  } tte_t;

  function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
    return {VPN_W{1'b1}} << (3 * sz);
  endfunction

  function automatic logic [PPN_W-1:0] ppn_mask(input logic [1:0] sz);
    return {PPN_W{1'b1}} << (3 * sz);
  endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [IDX_W-1:0]         ld_idx,
  input  tte_t                     ld_entry,
  input  logic                     hit_set,
  input  logic [IDX_W-1:0]         hit_idx,
  output tte_t [ENTRIES-1:0]       ent,
  output logic [ENTRIES-1:0]       used
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent  <= '0;
      used <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ld_en && ld_idx == IDX_W'(i)) begin
          ent[i]  <= ld_entry;
          used[i] <= 1'b0;
        end else if (hit_set && hit_idx == IDX_W'(i)) begin
          used[i] <= 1'b1;
        end
      end
    end
  end

  // R9: a freshly written slot starts with its used flag clear
  a_r9_load_clears_used: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !used[$past(ld_idx)] && ent[$past(ld_idx)] == $past(ld_entry));
endmodule

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  tte_t [ENTRIES-1:0] ent,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [CTX_W-1:0]   ctx,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign m[g] = ent[g].valid
                && (ent[g].glob || ent[g].ctx == ctx)
                && (((ent[g].tag ^ vpn) & vpn_mask(ent[g].size)) == '0);
  end

  always_comb begin
    hit = |m;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_fault_regs.sv
module tlb_fault_regs import tlb_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_fault,
  input  logic             take_miss,
  input  logic             clr,
  input  logic [FSR_W-3:0] fields,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q,
  output logic [VA_W-1:0]  tag_q
);
  logic still_valid;
  assign still_valid = fsr_q[0] && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
      tag_q <= '0;
    end else begin
      if (take_fault) begin
        fsr_q <= {fields, still_valid, 1'b1};
        far_q <= va;
      end else if (clr) begin
        fsr_q <= '0;
      end
      if (take_fault || take_miss)
        tag_q <= {va[VA_W-1:CTX_W], ctx};
    end
  end

  a_r10_fault_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> fsr_q[0] && far_q == $past(va));
  a_r11_overwrite_flag: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault && fsr_q[0] && !clr |=> fsr_q[1]);
  a_r12_miss_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    take_miss && !clr |=> $stable(far_q) && $stable(fsr_q));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [VA_W-1:0]   ld_va,
  input  logic [CTX_W-1:0]  ld_ctx,
  input  logic              ld_valid,
  input  logic              ld_global,
  input  logic [1:0]        ld_size,
  input  logic [PPN_W-1:0]  ld_ppn,
  input  logic              ld_priv,
  input  logic              ld_wr,
  input  logic              ld_nfo,
  input  logic              ld_se,
  input  logic              ld_ie,
  input  logic [CTX_W-1:0]  ctx_primary,
  input  logic [CTX_W-1:0]  ctx_secondary,
  input  logic              trap_nz,
  input  logic              priv_mode,
  input  logic              fsr_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_space,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              rsp_wr_ok,
  output logic              rsp_ie,
  output logic [FSR_W-1:0]  fsr,
  output logic [VA_W-1:0]   far,
  output logic [VA_W-1:0]   tag_access,
  output logic [ENTRIES-1:0] entry_used
);
  tte_t [ENTRIES-1:0] ent;
  tte_t               ld_entry;
  tte_t               sel;
  kind_e              kind;
  space_e             space;
  logic [CTX_W-1:0]   lk_ctx;
  logic [1:0]         ctype;
  logic               m_hit, bypass, accept;
  logic [IDX_W-1:0]   m_idx;
  logic               ft_priv, ft_se, ft_nfo;
  code_e              code_n;
  logic [PPN_W-1:0]   ppn_n, pmask;
  logic               wr_n, ie_n;

  assign ld_entry = '{valid: ld_valid, glob: ld_global, size: ld_size,
                      tag: ld_va[VA_W-1:PG_LSB], ctx: ld_ctx, ppn: ld_ppn,
                      priv: ld_priv, wr: ld_wr, nfo: ld_nfo, se: ld_se, ie: ld_ie};

  assign kind      = kind_e'(req_kind);
  assign space     = space_e'(req_space);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign bypass    = kind != K_FETCH && space == S_BYPASS;

  always_comb begin
    if (kind == K_FETCH) begin
      lk_ctx = trap_nz ? '0 : ctx_primary;
      ctype  = trap_nz ? 2'd2 : 2'd0;
    end else begin
      unique case (space)
        S_PRIM:  begin lk_ctx = ctx_primary;   ctype = 2'd0; end
        S_SEC:   begin lk_ctx = ctx_secondary; ctype = 2'd1; end
        S_NUC:   begin lk_ctx = '0;            ctype = 2'd2; end
        default: begin lk_ctx = '0;            ctype = 2'd3; end
      endcase
    end
  end

  tlb_array #(.ENTRIES(ENTRIES)) u_array (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_entry(ld_entry),
    .hit_set(accept && code_n == C_HIT && !bypass), .hit_idx(m_idx),
    .ent(ent), .used(entry_used));

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ent(ent), .vpn(req_va[VA_W-1:PG_LSB]), .ctx(lk_ctx), .hit(m_hit), .idx(m_idx));

  assign sel   = ent[m_idx];
  assign pmask = ppn_mask(sel.size);

  always_comb begin
    ft_priv = 1'b0;
    ft_se   = 1'b0;
    ft_nfo  = 1'b0;
    code_n  = C_MISS;
    ppn_n   = '0;
    wr_n    = 1'b0;
    ie_n    = 1'b0;
    if (bypass) begin
      code_n = C_HIT;
      ppn_n  = req_va[PA_W-1:PG_LSB];
      wr_n   = 1'b1;
    end else if (m_hit) begin
      ft_priv = sel.priv && req_user;
      if (kind != K_FETCH) begin
        ft_se  = kind == K_NFLOAD && sel.se;
        ft_nfo = kind != K_NFLOAD && sel.nfo;
      end
      if (ft_priv || ft_se || ft_nfo) begin
        code_n = C_FAULT;
      end else if (kind == K_STORE && !sel.wr) begin
        code_n = C_PROT;
      end else begin
        code_n = C_HIT;
        ppn_n  = (sel.ppn & pmask) | (req_va[PA_W-1:PG_LSB] & ~pmask);
        wr_n   = kind != K_FETCH && sel.wr;
        ie_n   = sel.ie;
      end
    end
  end

  tlb_fault_regs u_fault (
    .clk(clk), .rst_n(rst_n),
    .take_fault(accept && (code_n == C_FAULT || code_n == C_PROT)),
    .take_miss(accept && code_n == C_MISS),
    .clr(fsr_clr),
    .fields({ft_nfo, ft_se, ft_priv, priv_mode, kind == K_NFLOAD, kind == K_STORE, ctype}),
    .va(req_va), .ctx(lk_ctx),
    .fsr_q(fsr), .far_q(far), .tag_q(tag_access));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_ppn   <= '0;
      rsp_wr_ok <= 1'b0;
      rsp_ie    <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_code  <= code_n;
      rsp_ppn   <= ppn_n;
      rsp_wr_ok <= wr_n;
      rsp_ie    <= ie_n;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R13: a stalled response must not change
  a_r13_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_ppn)
                                && $stable(rsp_wr_ok) && $stable(rsp_ie));
  // R13: every accepted request yields a response on the next cycle
  a_r13_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int N = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ld_en = 0, ld_valid = 0, ld_global = 0, ld_priv = 0, ld_wr = 0;
  logic        ld_nfo = 0, ld_se = 0, ld_ie = 0;
  logic [5:0]  ld_idx = 0;
  logic [63:0] ld_va = 0;
  logic [12:0] ld_ctx = 0, ctx_primary = 0, ctx_secondary = 0;
  logic [1:0]  ld_size = 0;
  logic [27:0] ld_ppn = 0;
  logic        trap_nz = 0, priv_mode = 0, fsr_clr = 0;
  logic        req_valid = 0, req_user = 0, rsp_ready = 1;
  logic [63:0] req_va = 0;
  logic [1:0]  req_kind = 0, req_space = 0;
  logic        req_ready, rsp_valid, rsp_wr_ok, rsp_ie;
  logic [1:0]  rsp_code;
  logic [27:0] rsp_ppn;
  logic [9:0]  fsr;
  logic [63:0] far, tag_access;
  logic [63:0] entry_used;

  always #10 clk = ~clk;

  tlb_xlate u_tlb_xlate (.*);

  // bench model
  logic        mv[N], mg[N], mpr[N], mw[N], mn[N], ms[N], mi[N];
  logic [1:0]  msz[N];
  logic [50:0] mtag[N];
  logic [12:0] mctx[N];
  logic [27:0] mppn[N];
  logic [63:0] mused;
  logic [9:0]  efsr;
  logic [63:0] efar, etag;
  logic [1:0]  ecode;
  logic [27:0] eppn;
  logic        ewr, eie;
  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic ld(input int idx, input logic [63:0] va, input logic [12:0] ctx, input logic v,
                    input logic g, input logic [1:0] sz, input logic [27:0] ppn, input logic pr,
                    input logic w, input logic nfo, input logic se, input logic ie);
    @(negedge clk);
    ld_en = 1; ld_idx = 6'(idx); ld_va = va; ld_ctx = ctx; ld_valid = v; ld_global = g;
    ld_size = sz; ld_ppn = ppn; ld_priv = pr; ld_wr = w; ld_nfo = nfo; ld_se = se; ld_ie = ie;
    @(negedge clk);
    ld_en = 0;
    mv[idx] = v; mg[idx] = g; msz[idx] = sz; mtag[idx] = va[63:13]; mctx[idx] = ctx;
    mppn[idx] = ppn; mpr[idx] = pr; mw[idx] = w; mn[idx] = nfo; ms[idx] = se; mi[idx] = ie;
    mused[idx] = 0;
  endtask

  // predict the result of the request currently on the inputs and update the model
  task automatic predict();
    logic [12:0] c; logic [1:0] ct; int hit; logic fp, fs, fn;
    logic [50:0] vm; logic [27:0] pm;
    if (req_kind == 3) begin c = trap_nz ? 0 : ctx_primary; ct = trap_nz ? 2 : 0; end
    else begin
      case (req_space)
        0: begin c = ctx_primary; ct = 0; end
        1: begin c = ctx_secondary; ct = 1; end
        2: begin c = 0; ct = 2; end
        default: begin c = 0; ct = 3; end
      endcase
    end
    ecode = 3; eppn = 0; ewr = 0; eie = 0; fp = 0; fs = 0; fn = 0;
    if (req_kind != 3 && req_space == 3) begin
      ecode = 0; eppn = req_va[40:13]; ewr = 1;
      return;
    end
    hit = -1;
    for (int i = 0; i < N; i++) begin
      vm = ~51'(0) << (3 * msz[i]);
      if (hit < 0 && mv[i] && (mg[i] || mctx[i] == c) && ((mtag[i] & vm) == (req_va[63:13] & vm)))
        hit = i;
    end
    if (hit < 0) begin
      etag = {req_va[63:13], c};
      return;
    end
    fp = mpr[hit] && req_user;
    if (req_kind != 3) begin
      fs = req_kind == 2 && ms[hit];
      fn = req_kind != 2 && mn[hit];
    end
    if (fp || fs || fn) ecode = 1;
    else if (req_kind == 1 && !mw[hit]) ecode = 2;
    else begin
      ecode = 0;
      pm = ~28'(0) << (3 * msz[hit]);
      eppn = (mppn[hit] & pm) | (req_va[40:13] & ~pm);
      ewr = req_kind != 3 && mw[hit];
      eie = mi[hit];
      mused[hit] = 1;
    end
    if (ecode != 0) begin
      efsr = {fn, fs, fp, priv_mode, req_kind == 2, req_kind == 1, ct, efsr[0], 1'b1};
      efar = req_va;
      etag = {req_va[63:13], c};
    end
  endtask

  task automatic check_all(input string rq);
    chk(rsp_valid == 1, rq, 64'(rsp_valid), 1);
    chk(rsp_code == ecode, rq, 64'(rsp_code), 64'(ecode));
    chk(rsp_ppn == eppn, rq, 64'(rsp_ppn), 64'(eppn));
    chk(rsp_wr_ok == ewr && rsp_ie == eie, rq, {rsp_wr_ok, rsp_ie}, {ewr, eie});
    chk(fsr == efsr, rq, 64'(fsr), 64'(efsr));
    chk(far == efar, rq, far, efar);
    chk(tag_access == etag, rq, tag_access, etag);
    chk(entry_used == mused, rq, entry_used, mused);
  endtask

  task automatic lk(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] sp,
                    input logic usr, input string rq);
    @(negedge clk);
    req_va = va; req_kind = kind; req_space = sp; req_user = usr; req_valid = 1;
    predict();
    @(negedge clk);
    req_valid = 0;
    check_all(rq);
  endtask

  task automatic clear_status();
    @(negedge clk); fsr_clr = 1;
    @(negedge clk); fsr_clr = 0;
    efsr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mg[i] = 0; msz[i] = 0; mtag[i] = 0; mctx[i] = 0; mppn[i] = 0;
      mpr[i] = 0; mw[i] = 0; mn[i] = 0; ms[i] = 0; mi[i] = 0;
    end
    mused = 0; efsr = 0; efar = 0; etag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R13, R10)
    chk(rsp_valid == 0 && req_ready == 1, "R13 reset", {rsp_valid, req_ready}, 2'b01);
    chk(fsr == 0 && far == 0 && tag_access == 0 && entry_used == 0, "R10 reset", fsr, 0);

    ctx_primary = 5; ctx_secondary = 7;
    ld(0, 64'h0000_1234_0040_2000, 5, 1, 0, 0, 28'h0123456, 0, 1, 0, 0, 1);
    lk(64'h0000_1234_0040_2abc, 0, 0, 0, "R1 R3 R8 primary hit");
    ctx_primary = 6;
    lk(64'h0000_1234_0040_2000, 0, 0, 0, "R12 R4 context mismatch miss");
    ctx_secondary = 5;
    lk(64'h0000_1234_0040_2000, 1, 1, 0, "R4 secondary store hit");
    // large global page, 4 MiB
    ld(1, 64'h0000_0000_8000_0000, 9, 1, 1, 3, 28'h0ABCDEF, 0, 0, 0, 0, 0);
    lk(64'h0000_0000_802A_6000, 0, 2, 0, "R2 R3 4MiB global nucleus");
    // 64 KiB page boundary
    ld(2, 64'h0000_0000_0100_0000, 0, 1, 0, 1, 28'h0000100, 0, 1, 0, 0, 0);
    lk(64'h0000_0000_0100_E000, 0, 2, 0, "R2 64KiB last page inside");
    lk(64'h0000_0000_0101_0000, 0, 2, 0, "R2 64KiB just past miss");
    // duplicate match, lowest index wins
    ld(9, 64'h0000_0000_0200_0000, 0, 1, 0, 0, 28'h0000999, 0, 1, 0, 0, 0);
    ld(4, 64'h0000_0000_0200_0000, 0, 1, 1, 0, 28'h0000444, 0, 1, 0, 0, 0);
    lk(64'h0000_0000_0200_0000, 0, 2, 0, "R5 lowest index wins");
    // combined data fault bits
    priv_mode = 0;
    ld(10, 64'h0000_0000_0300_0000, 0, 1, 0, 0, 28'h0000010, 1, 1, 1, 1, 0);
    lk(64'h0000_0000_0300_0008, 0, 2, 1, "R6 user priv + no-fault-only");
    lk(64'h0000_0000_0300_0010, 2, 2, 1, "R6 R11 nf load side-effect overwrite");
    clear_status();
    lk(64'h0000_0000_0300_0000, 2, 2, 0, "R6 R11 after clear, side-effect only");
    // protection trap versus fault
    ld(11, 64'h0000_0000_0400_0000, 0, 1, 0, 0, 28'h0000011, 1, 0, 0, 0, 0);
    lk(64'h0000_0000_0400_0000, 1, 2, 0, "R7 store to read-only");
    lk(64'h0000_0000_0400_0000, 1, 2, 1, "R7 R6 user store priv beats protection");
    lk(64'h0000_0000_0400_0000, 0, 2, 0, "R8 load of read-only hits");
    // fetch context selection
    priv_mode = 1;
    ld(12, 64'h0000_0000_0500_0000, 0, 1, 0, 0, 28'h0000012, 1, 1, 1, 1, 1);
    trap_nz = 1;
    lk(64'h0000_0000_0500_0000, 3, 1, 1, "R4 R6 fetch nucleus priv fault");
    lk(64'h0000_0000_0500_0000, 3, 1, 0, "R8 fetch ignores nfo and wr");
    trap_nz = 0;
    ctx_primary = 0;
    lk(64'h0000_0000_0500_0000, 3, 3, 0, "R4 fetch primary at level 0");
    ctx_primary = 3;
    lk(64'h0000_0000_0500_0000, 3, 0, 0, "R12 fetch miss");
    // untranslated
    lk(64'hFFFF_0000_1357_9000, 1, 3, 1, "R14 untranslated access");
    // reload clears used, invalid slot never matches
    ld(0, 64'h0000_1234_0040_2000, 5, 0, 0, 0, 28'h0123456, 0, 1, 0, 0, 1);
    chk(entry_used[0] == 0, "R9 reload clears used", 64'(entry_used[0]), 0);
    ctx_secondary = 5;
    lk(64'h0000_1234_0040_2000, 0, 1, 0, "R1 R9 invalid slot misses");
    // back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_va = 64'h0000_0000_0200_0000; req_kind = 0; req_space = 2; req_user = 0; req_valid = 1;
    predict();
    @(negedge clk);
    chk(rsp_valid == 1 && req_ready == 0, "R13 stall", {rsp_valid, req_ready}, 2'b10);
    req_va = 64'h0000_0000_0600_0000;
    @(negedge clk);
    chk(rsp_code == ecode && rsp_ppn == eppn, "R13 held response", 64'(rsp_ppn), 64'(eppn));
    rsp_ready = 1;
    predict();
    @(negedge clk);
    req_valid = 0;
    check_all("R13 after release");
    @(negedge clk);
    chk(rsp_valid == 0, "R13 drained", 64'(rsp_valid), 0);

    // random phase
    for (int i = 0; i < N; i++)
      ld(i, 64'($urandom) & 64'h0000_0000_01C3_E000, 13'($urandom_range(0, 2)),
         $urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0, 2'($urandom), 28'($urandom),
         $urandom_range(0, 3) == 0, 1'($urandom), $urandom_range(0, 5) == 0,
         $urandom_range(0, 3) == 0, 1'($urandom));
    for (int n = 0; n < 600; n++) begin
      ctx_primary = 13'($urandom_range(0, 2));
      ctx_secondary = 13'($urandom_range(0, 2));
      trap_nz = 1'($urandom); priv_mode = 1'($urandom);
      if ($urandom_range(0, 15) == 0) clear_status();
      if ($urandom_range(0, 19) == 0)
        ld($urandom_range(0, N - 1), 64'($urandom) & 64'h0000_0000_01C3_E000,
           13'($urandom_range(0, 2)), 1, 1'($urandom), 2'($urandom), 28'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      lk((64'($urandom) & 64'h0000_0000_01C3_E000) | 64'($urandom_range(0, 8191)),
         2'($urandom), 2'($urandom_range(0, 7) == 0 ? 3 : $urandom_range(0, 2)),
         1'($urandom), "R1 R2 R3 R5 R6 R7 R8 R10 R12 random");
    end
    finish_run();
  end
endmodule